// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of an Ethernet receive path and watches the destination address of each incoming frame as its bytes stream in. Once it has seen the six address bytes it reports whether the frame is accepted and whether the address missed. The MAC then uses accept to keep or drop the frame, and records miss in the receive status. The byte stream is qualified by a valid strobe. A start strobe marks the first byte of a frame and a last strobe marks its final byte.

Four filters are available. Broadcast frames can be allowed or refused. Group-addressed frames are looked up in a 64-bin hash table whose index comes from the CRC-32 of the address. Individual addresses are compared exactly against the programmed station address. A promiscuous setting keeps frames that missed but still flags them as missed. The CRC is built one byte per cycle as the address arrives, so the decision needs no extra latency beyond one register stage.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_miss` are low, and no decision is issued until a frame is started with `rx_sof`.
- R2: A decision (`dec_valid` high for one cycle) appears in the cycle after the sixth address byte is taken. Bytes after the sixth, and bytes arriving while no frame is open, cause no decision and no state change until the next `rx_sof`.
- R3: An address of six 0xFF bytes is a broadcast. It is a hit when `cfg_bcast_reject` is 0 and a miss when it is 1.
- R4: A non-broadcast address whose first byte has bit 0 set is looked up in the hash table. The CRC uses polynomial 0x04C11DB7 and seed 0xFFFFFFFF, takes the bits of each byte least significant first, and is not inverted. Its bits 31:26 form the index. An index of 0..31 selects that bit of `hash_lo`, and an index of 32..63 selects bit (index-32) of `hash_hi`. A set bit is a hit.
- R5: When `cfg_hash_all` is 1, every non-broadcast address uses the hash lookup of R4, including individual addresses.
- R6: Any other address is a hit only when byte 0 equals `stn_addr_hi[15:8]`, byte 1 equals `stn_addr_hi[7:0]`, and bytes 2..5 equal `stn_addr_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` respectively.
- R7: A frame whose last byte arrives before six bytes are taken produces a miss decision in the cycle after that last byte. A last strobe on the sixth byte gives the normal decision.
- R8: A missed frame has `dec_miss`=1. It has `dec_accept`=0 unless `cfg_promisc` is 1, in which case `dec_accept`=1.
- R9: An `rx_sof` while a frame's address is still incomplete discards the partial address; only the new frame produces a decision.
- R10: A hit gives `dec_accept`=1 and `dec_miss`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A byte is present on `rx_data` this cycle |
| rx_sof | input | 1 | First byte of a frame (qualified by `rx_valid`) |
| rx_last | input | 1 | Final byte of a frame (qualified by `rx_valid`) |
| rx_data | input | 8 | Received byte |
| cfg_bcast_reject | input | 1 | Treat broadcast as a miss |
| cfg_hash_all | input | 1 | Use the hash lookup for individual addresses too |
| cfg_promisc | input | 1 | Accept frames that missed |
| stn_addr_hi | input | 16 | Station address bytes 0 (15:8) and 1 (7:0) |
| stn_addr_lo | input | 32 | Station address bytes 2..5, byte 2 in 31:24 |
| hash_lo | input | 32 | Hash bins 0..31 |
| hash_hi | input | 32 | Hash bins 32..63 |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame is to be kept |
| dec_miss | output | 1 | Address did not match |

## Verification
The assertions check the following on every cycle:
- accept and miss stay low between decisions;
- a hit always accepts, and a miss never accepts without promiscuous mode;
- a decision only follows a taken byte, and a broadcast under rejection always misses;
- the byte counter never passes six, a start strobe reopens the frame, and bytes after the address leave the captured address and CRC unchanged.

Only the bench scenarios can show that the hash index, the choice between the low and high word, and the byte-to-field mapping of the exact compare are right. They are also needed to show that decisions arrive in exactly the right cycle, and that short frames, restarted frames and trailing bytes produce exactly the expected number of decisions.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  localparam int unsigned DA_BYTES   = 6;
  localparam int unsigned DA_W       = 8 * DA_BYTES;
  localparam int unsigned CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam int unsigned HASH_IDX_W = 6;
  localparam int unsigned HASH_WORD  = 32;
  localparam int unsigned CNT_W      = $clog2(DA_BYTES + 1);

  typedef enum logic [1:0] {
    PATH_BCAST = 2'd0,
    PATH_HASH  = 2'd1,
    PATH_EXACT = 2'd2,
    PATH_SHORT = 2'd3
  } rxf_path_e;

  // Advance the CRC register by one byte, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_feed_byte(input logic [CRC_W-1:0] crc_in,
                                                     input logic [7:0] b);
    logic [CRC_W-1:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (c[CRC_W-1] ^ b[i]) c = {c[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   c = {c[CRC_W-2:0], 1'b0};
    end
    return c;
  endfunction

  // Pick one bin of the two-word hash table.
  function automatic logic hash_bin(input logic [HASH_IDX_W-1:0] idx,
                                    input logic [HASH_WORD-1:0] lo,
                                    input logic [HASH_WORD-1:0] hi);
    return idx[HASH_IDX_W-1] ? hi[idx[HASH_IDX_W-2:0]] : lo[idx[HASH_IDX_W-2:0]];
  endfunction
endpackage

// File: rtl/rxf_dest_capture.sv
`timescale 1ns/1ps
module rxf_dest_capture
  import rxf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sof,
  input  logic                     in_last,
  input  logic [7:0]               in_data,
  output logic [DA_BYTES-1:0][7:0] da_q,
  output logic [CRC_W-1:0]         crc_q,
  output logic                     full_pulse,
  output logic                     short_pulse,
  output logic                     byte_take
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DA_BYTES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  // cnt_q: 0 = no frame open, 1..5 = address bytes seen, FULL = closed
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] cnt_next;
  logic [CRC_W-1:0] crc_base;

  always_comb begin
    byte_take = in_valid && (in_sof || (cnt_q != '0 && cnt_q < CNT_FULL));
    pos       = in_sof ? '0 : cnt_q;
    cnt_next  = pos + CNT_ONE;
    crc_base  = in_sof ? CRC_SEED : crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      da_q        <= '0;
      crc_q       <= CRC_SEED;
      full_pulse  <= 1'b0;
      short_pulse <= 1'b0;
    end else begin
      full_pulse  <= byte_take && (cnt_next == CNT_FULL);
      short_pulse <= byte_take && in_last && (cnt_next < CNT_FULL);
      if (byte_take) begin
        da_q[pos] <= in_data;
        crc_q     <= crc_feed_byte(crc_base, in_data);
        cnt_q     <= in_last ? CNT_FULL : cnt_next;
      end
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  assert_closed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_FULL && in_valid && !in_sof) |=> ($stable(crc_q) && $stable(da_q)));

  assert_sof_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !in_last) |=> (cnt_q == CNT_ONE));

  assert_one_pulse_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_pulse && short_pulse));
endmodule

// File: rtl/rxf_classify.sv
`timescale 1ns/1ps
module rxf_classify
  import rxf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DA_BYTES-1:0][7:0] da,
  input  logic [CRC_W-1:0]         crc,
  input  logic                     is_short,
  input  logic                     bcast_reject,
  input  logic                     hash_all,
  input  logic [DA_W-1:0]          station,
  input  logic [HASH_WORD-1:0]     hash_lo,
  input  logic [HASH_WORD-1:0]     hash_hi,
  output rxf_path_e                path,
  output logic                     hit
);
  logic [DA_BYTES-1:0] byte_eq;
  logic [DA_BYTES-1:0] byte_ff;
  logic                all_ones;
  logic                exact_eq;
  logic                group_addr;
  logic [HASH_IDX_W-1:0] hash_idx;

  // Station byte k sits at the k-th most significant byte of the station vector.
  for (genvar k = 0; k < DA_BYTES; k++) begin : g_byte
    assign byte_eq[k] = (da[k] == station[DA_W-1-8*k -: 8]);
    assign byte_ff[k] = (da[k] == 8'hFF);
  end

  always_comb begin
    all_ones   = &byte_ff;
    exact_eq   = &byte_eq;
    group_addr = da[0][0];
    hash_idx   = crc[CRC_W-1 -: HASH_IDX_W];
    if (is_short)                   path = PATH_SHORT;
    else if (all_ones)              path = PATH_BCAST;
    else if (group_addr || hash_all) path = PATH_HASH;
    else                            path = PATH_EXACT;
    unique case (path)
      PATH_BCAST: hit = !bcast_reject;
      PATH_HASH:  hit = hash_bin(hash_idx, hash_lo, hash_hi);
      PATH_EXACT: hit = exact_eq;
      default:    hit = 1'b0;
    endcase
  end

  assert_short_never_hits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_short |-> !hit);
endmodule

// File: rtl/rx_dest_filter.sv
`timescale 1ns/1ps
module rx_dest_filter
  import rxf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_last,
  input  logic [7:0]  rx_data,
  input  logic        cfg_bcast_reject,
  input  logic        cfg_hash_all,
  input  logic        cfg_promisc,
  input  logic [15:0] stn_addr_hi,
  input  logic [31:0] stn_addr_lo,
  input  logic [31:0] hash_lo,
  input  logic [31:0] hash_hi,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic        dec_miss
);
  logic [DA_BYTES-1:0][7:0] da_q;
  logic [CRC_W-1:0]         crc_q;
  logic                     full_pulse;
  logic                     short_pulse;
  logic                     byte_take;
  rxf_path_e                path;
  logic                     hit;

  rxf_dest_capture u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rx_valid),
    .in_sof     (rx_sof),
    .in_last    (rx_last),
    .in_data    (rx_data),
    .da_q       (da_q),
    .crc_q      (crc_q),
    .full_pulse (full_pulse),
    .short_pulse(short_pulse),
    .byte_take  (byte_take)
  );

  rxf_classify u_classify (
    .clk         (clk),
    .rst_n       (rst_n),
    .da          (da_q),
    .crc         (crc_q),
    .is_short    (short_pulse),
    .bcast_reject(cfg_bcast_reject),
    .hash_all    (cfg_hash_all),
    .station     ({stn_addr_hi, stn_addr_lo}),
    .hash_lo     (hash_lo),
    .hash_hi     (hash_hi),
    .path        (path),
    .hit         (hit)
  );

  always_comb begin
    dec_valid  = full_pulse | short_pulse;
    dec_accept = dec_valid & (hit | cfg_promisc);
    dec_miss   = dec_valid & ~hit;
  end

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && !dec_miss));

  assert_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(byte_take));

  assert_bcast_rejected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && path == PATH_BCAST && cfg_bcast_reject) |-> dec_miss);

  assert_miss_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_miss && !cfg_promisc) |-> !dec_accept);

  assert_hit_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_miss) |-> dec_accept);
endmodule

// File: tb/tb_rx_dest_filter.sv
`timescale 1ns/1ps
module tb_rx_dest_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        cfg_bcast_reject = 1'b0, cfg_hash_all = 1'b0, cfg_promisc = 1'b0;
  logic [15:0] stn_addr_hi = 16'h0211;
  logic [31:0] stn_addr_lo = 32'h2233_4455;
  logic [31:0] hash_lo = '0, hash_hi = '0;
  logic        dec_valid, dec_accept, dec_miss;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;
  int    q_cyc[$];
  bit    q_acc[$];
  bit    q_miss[$];
  string q_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_dest_filter dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_last(rx_last),
    .rx_data(rx_data), .cfg_bcast_reject(cfg_bcast_reject), .cfg_hash_all(cfg_hash_all),
    .cfg_promisc(cfg_promisc), .stn_addr_hi(stn_addr_hi), .stn_addr_lo(stn_addr_lo),
    .hash_lo(hash_lo), .hash_hi(hash_hi), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_miss(dec_miss)
  );

  // Serial CRC over the 48 address bits, byte 0 first, each byte LSB first.
  function automatic logic [31:0] ref_crc(input logic [47:0] da);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int j = 0; j < 48; j++) begin
      logic fb;
      fb = r[31] ^ da[40 - 8*(j/8) + (j%8)];
      r  = r << 1;
      if (fb) r = r ^ 32'h04C1_1DB7;
    end
    return r;
  endfunction

  function automatic int ref_idx(input logic [47:0] da);
    logic [31:0] c = ref_crc(da);
    return int'(c[31:26]);
  endfunction

  // Returns {accept, miss}
  function automatic logic [1:0] model(input logic [47:0] da, input int n);
    bit h;
    int ix;
    if (n < 6)                     h = 1'b0;
    else if (da == 48'hFFFF_FFFF_FFFF) h = !cfg_bcast_reject;
    else if (da[40] || cfg_hash_all) begin
      ix = ref_idx(da);
      h = (ix >= 32) ? hash_hi[ix-32] : hash_lo[ix];
    end else                       h = (da == {stn_addr_hi, stn_addr_lo});
    return {h | cfg_promisc, !h};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_sof = 1'b0; rx_last = 1'b0;
    end
  endtask

  task automatic put_byte(input logic [7:0] d, input bit s, input bit l);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = d; rx_sof = s; rx_last = l;
  endtask

  // Driver: streams a frame and pushes the expected decision into the scoreboard.
  task automatic send_frame(input logic [47:0] da, input int n, input bit last, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      logic [1:0] e;
      b = (k < 6) ? da[47-8*k -: 8] : (8'hA5 ^ 8'(k));
      put_byte(b, k == 0, last && (k == n-1));
      if (k == 5 || (n < 6 && last && k == n-1)) begin
        e = model(da, n);
        q_cyc.push_back(cyc + 1); q_acc.push_back(e[1]);
        q_miss.push_back(e[0]); q_tag.push_back(tag);
      end
    end
    idle(2);
  endtask

  // Monitor: pops and compares each decision.
  always @(negedge clk) begin
    if (rst_n && !done && dec_valid) begin
      checks++;
      if (q_cyc.size() == 0) begin
        failures++;
        $display("FAIL R2/R9 unexpected decision at cycle %0d: actual acc=%0b miss=%0b expected none",
                 cyc, dec_accept, dec_miss);
      end else begin
        int ec; bit ea, em; string t;
        ec = q_cyc.pop_front(); ea = q_acc.pop_front();
        em = q_miss.pop_front(); t = q_tag.pop_front();
        if (ec != cyc || ea != dec_accept || em != dec_miss) begin
          failures++;
          $display("FAIL %s: actual cyc=%0d acc=%0b miss=%0b expected cyc=%0d acc=%0b miss=%0b",
                   t, cyc, dec_accept, dec_miss, ec, ea, em);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [47:0] stn, mc1, mc2, mc3;
    int ix;
    stn = {16'h0211, 32'h2233_4455};
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (dec_valid || dec_accept || dec_miss) begin
      failures++;
      $display("FAIL R1 reset: actual %0b%0b%0b expected 000", dec_valid, dec_accept, dec_miss);
    end
    rst_n = 1'b1;
    idle(2);
    // R1: stray bytes without a start strobe give nothing
    put_byte(8'h02, 1'b0, 1'b0); put_byte(8'h11, 1'b0, 1'b1); idle(3);

    send_frame(stn, 6, 1'b1, "R6 exact hit (R10)");
    send_frame({stn[47:8], 8'h56}, 8, 1'b1, "R6 last byte differs");
    send_frame({8'h04, stn[39:0]}, 6, 1'b0, "R6 first byte differs");
    send_frame({16'h1122, 32'h0211_2233}, 6, 1'b0, "R6 field order");

    send_frame(48'hFFFF_FFFF_FFFF, 6, 1'b1, "R3 broadcast allowed");
    cfg_bcast_reject = 1'b1;
    send_frame(48'hFFFF_FFFF_FFFF, 6, 1'b1, "R3 broadcast refused");
    cfg_bcast_reject = 1'b0;

    mc1 = 48'h0100_5E00_0001;
    ix = ref_idx(mc1);
    if (ix >= 32) hash_hi = 32'h1 << (ix-32); else hash_lo = 32'h1 << ix;
    send_frame(mc1, 6, 1'b1, "R4 multicast bin set");
    hash_lo = ~hash_lo; hash_hi = ~hash_hi;
    send_frame(mc1, 6, 1'b1, "R4 multicast bin clear");
    hash_lo = 32'hFFFF_FFFF; hash_hi = 32'h0;
    mc2 = 48'h3333_0000_0001;
    mc3 = 48'h0100_5E7F_FFFA;
    send_frame(mc2, 6, 1'b1, "R4 low/high word select A");
    send_frame(mc3, 6, 1'b1, "R4 low/high word select B");
    hash_lo = 32'h0; hash_hi = 32'hFFFF_FFFF;
    send_frame(mc2, 6, 1'b1, "R4 low/high word select C");
    send_frame(mc1, 6, 1'b1, "R4 low/high word select D");

    cfg_hash_all = 1'b1; hash_lo = 32'h0; hash_hi = 32'h0;
    send_frame(stn, 6, 1'b1, "R5 hash-all overrides exact");
    hash_lo = 32'hFFFF_FFFF; hash_hi = 32'hFFFF_FFFF;
    send_frame({8'h08, stn[39:0]}, 6, 1'b1, "R5 hash-all individual hit");
    cfg_hash_all = 1'b0; hash_lo = 32'h0; hash_hi = 32'h0;

    send_frame(stn, 4, 1'b1, "R7 short frame");
    send_frame(48'hFFFF_FFFF_FFFF, 1, 1'b1, "R7 one-byte frame");
    send_frame(stn, 6, 1'b1, "R7 last on sixth byte");

    cfg_promisc = 1'b1;
    send_frame({stn[47:8], 8'h00}, 6, 1'b1, "R8 promisc keeps miss");
    send_frame(stn, 3, 1'b1, "R8 promisc short");
    send_frame(stn, 6, 1'b1, "R10 promisc hit");
    cfg_promisc = 1'b0;
    send_frame(48'h0A0B_0C0D_0E0F, 6, 1'b1, "R8 miss dropped");

    // R9: partial address then restart; only the new frame decides
    put_byte(8'hFF, 1'b1, 1'b0); put_byte(8'hFF, 1'b0, 1'b0); put_byte(8'hFF, 1'b0, 1'b0);
    send_frame(stn, 6, 1'b1, "R9 restart discards partial");

    // R2: long frame, then trailing bytes without a start strobe
    send_frame(stn, 12, 1'b0, "R2 long frame");
    put_byte(8'h01, 1'b0, 1'b0); put_byte(8'h02, 1'b0, 1'b1); idle(4);

    checks++;
    if (q_cyc.size() != 0) begin
      failures++;
      $display("FAIL R2 missing decisions: actual %0d pending expected 0", q_cyc.size());
    end
    finish_run();
  end
endmodule